// File: doc/BRIEF.md
# Video Frame Timer with VRAM Access Gate

This block keeps the vertical timing of a simple video display processor and uses it to decide which CPU writes into video memory may go through. It divides the CPU clock into scan lines of 228 cycles. It divides lines into frames of 262 lines (60 Hz) or 313 lines (50 Hz). The first 192 lines of every frame are active display and the rest are blanking. When blanking begins, a vertical-blank flag is set. The flag can be read as bit 7 of a status byte, is cleared by reading, and drives an interrupt line when that is enabled.

CPU write strobes arrive on a valid/ready pair. `wr_ready` is the gate's decision for the current cycle and does not depend on `wr_valid`. A write is accepted in a cycle where both are high. There is no back-pressure: a strobe that arrives while `wr_ready` is low is dropped, not held, and the CPU is never stalled. Each dropped strobe sets a sticky overrun bit and advances a saturating drop counter.

The gate has two rules. Under the region rule, which is the default, writes pass every cycle in blanking, and during active display they must be spaced at least `GAP_ACTIVE` cycles apart. Under the fixed rule, writes must be spaced at least `GAP_STRICT` cycles apart everywhere.

Top module: `vframe_gate`

## Requirements
- R1: `cycle` counts 0 to `LINE_CYCLES`-1 and then returns to 0. `line` advances by one in the cycle after `cycle` was `LINE_CYCLES`-1.
- R2: With `mode_50`=0 a frame is `LINES_60` lines long, and with `mode_50`=1 it is `LINES_50` lines long. After the last line, `line` returns to 0, and `frame_start` is high for exactly that one cycle (line 0, cycle 0). `frame_start` stays low after reset.
- R3: `in_blank` is high exactly when `line` >= `ACTIVE_LINES`.
- R4: The vertical-blank flag becomes 1 in the cycle where `line`=`ACTIVE_LINES` and `cycle`=0. The flag is shown in `stat_data[7]`, and `stat_data[6:0]` are 0.
- R5: When `stat_rd` is high in a cycle, the flag reads 0 from the next cycle on. If blanking starts at that same edge, the flag is set and the read does not clear it.
- R6: `irq` equals the flag AND `irq_en` in every cycle.
- R7: When `strict_gap`=0, `wr_ready` is high in every blanking cycle, so back-to-back writes are all accepted.
- R8: When `strict_gap`=0, in active display `wr_ready` is high only if at least `GAP_ACTIVE` cycles have passed since the last accepted write. The cycle of that write counts as cycle 0, so the next write may come at +`GAP_ACTIVE`.
- R9: When `strict_gap`=1, `wr_ready` is high only if at least `GAP_STRICT` cycles have passed since the last accepted write, in both active display and blanking.
- R10: Each dropped strobe (`wr_valid` high, `wr_ready` low) sets `overrun` and adds one to `drop_count`. The counter stops at its maximum value. `err_clr` sets both to 0 at the next edge, and it wins over a drop in the same cycle.
- R11: Synchronous active-high `rst` sets `line` and `cycle` to 0 (active area), clears the flag, `overrun` and `drop_count`, and leaves the gate open as if the last write were long past.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_50 | input | 1 | 1 selects the 50 Hz frame length, 0 the 60 Hz frame length |
| strict_gap | input | 1 | 1 selects the fixed spacing rule |
| wr_valid | input | 1 | CPU write strobe |
| wr_ready | output | 1 | Gate open this cycle; valid and ready means accepted |
| stat_rd | input | 1 | Status read strobe |
| stat_data | output | 8 | Status byte, vertical-blank flag in bit 7 |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| err_clr | input | 1 | Clears overrun and drop count |
| overrun | output | 1 | Sticky dropped-write bit |
| drop_count | output | DROP_W | Saturating dropped-write count |
| line | output | LINE_W | Current scan line |
| cycle | output | CYC_W | Cycle within line |
| in_blank | output | 1 | Beam is in vertical blanking |
| frame_start | output | 1 | One-cycle pulse at line 0, cycle 0 |

## Verification
The bench shrinks the frame to a few short lines so that whole frames can be swept. It drives write strobes with every period from 1 to 7 cycles, under both spacing rules and both frame lengths. Periods shorter than the gap separate a correct drop count from an off-by-one spacing. Constant strobes separate blanking from active display under the region rule. Status reads are tried three ways: on every cycle, which catches the case where a set and a clear meet at the same edge; sparsely; and not at all. Long fixed-rule runs push the drop counter into saturation and then clear it.

// File: rtl/vfg_pkg.sv
package vfg_pkg;
  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/vfg_timebase.sv
module vfg_timebase #(
  parameter int LINE_CYCLES  = 228,
  parameter int ACTIVE_LINES = 192,
  parameter int LINES_60     = 262,
  parameter int LINES_50     = 313,
  parameter int LINE_W       = 9,
  parameter int CYC_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_50,
  output logic [LINE_W-1:0] line_o,
  output logic [CYC_W-1:0]  cyc_o,
  output logic              in_blank_o,
  output logic              frame_start_o,
  output logic              vbl_edge_o
);
  localparam logic [CYC_W-1:0]  CYC_LAST = CYC_W'(LINE_CYCLES - 1);
  localparam logic [LINE_W-1:0] ACT_LAST = LINE_W'(ACTIVE_LINES - 1);
  localparam logic [LINE_W-1:0] ACT_END  = LINE_W'(ACTIVE_LINES);

  logic [LINE_W-1:0] line_q, last_line;
  logic [CYC_W-1:0]  cyc_q;
  logic              fs_q, eol, wrap;

  assign last_line = mode_50 ? LINE_W'(LINES_50 - 1) : LINE_W'(LINES_60 - 1);
  assign eol       = (cyc_q == CYC_LAST);
  assign wrap      = eol && (line_q >= last_line);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= '0;
      line_q <= '0;
      fs_q   <= 1'b0;
    end else begin
      cyc_q <= eol ? '0 : cyc_q + 1'b1;
      if (eol) line_q <= wrap ? '0 : line_q + 1'b1;
      fs_q <= wrap;
    end
  end

  assign line_o        = line_q;
  assign cyc_o         = cyc_q;
  assign frame_start_o = fs_q;
  assign in_blank_o    = (line_q >= ACT_END);
  assign vbl_edge_o    = eol && (line_q == ACT_LAST);

  // R1
  cyc_range_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_q <= CYC_LAST);
  // R1
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    (eol && !wrap) |=> (line_q == $past(line_q) + 1'b1) && (cyc_q == '0));
  // R2
  frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fs_q |-> (line_q == '0) && (cyc_q == '0));
endmodule

// File: rtl/vfg_gate.sv
module vfg_gate
  import vfg_pkg::*;
#(
  parameter int GAP_ACTIVE = 28,
  parameter int GAP_STRICT = 22
) (
  input  logic clk,
  input  logic rst,
  input  logic strict,
  input  logic in_blank,
  input  logic wr_valid,
  output logic wr_ready,
  output logic drop_o
);
  localparam int GAP_MAX = max_of(max_of(GAP_ACTIVE, GAP_STRICT), 1);
  localparam int GW      = $clog2(GAP_MAX + 1);
  localparam logic [GW-1:0] SAT = GW'(GAP_MAX);

  logic [GW-1:0] since_q;
  logic          accept;

  always_comb begin
    if (strict) wr_ready = (since_q >= GW'(GAP_STRICT));
    else        wr_ready = in_blank || (since_q >= GW'(GAP_ACTIVE));
  end

  assign accept = wr_valid && wr_ready;
  assign drop_o = wr_valid && !wr_ready;

  always_ff @(posedge clk) begin
    if (rst)              since_q <= SAT;
    else if (accept)      since_q <= GW'(1);
    else if (since_q != SAT) since_q <= since_q + 1'b1;
  end

  // R7
  blank_open_chk: assert property (@(posedge clk) disable iff (rst)
    (!strict && in_blank) |-> wr_ready);

  generate
    if (GAP_STRICT > 1) begin : g_strict_chk
      // R9
      strict_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (strict && accept) |=> (!strict || !wr_ready));
    end
    if (GAP_ACTIVE > 1) begin : g_active_chk
      // R8
      active_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (!strict && accept) |=> (strict || in_blank || !wr_ready));
    end
  endgenerate
endmodule

// File: rtl/vfg_status.sv
module vfg_status #(
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vbl_edge,
  input  logic              stat_rd,
  input  logic              irq_en,
  input  logic              drop,
  input  logic              err_clr,
  output logic [7:0]        stat_data,
  output logic              irq,
  output logic              overrun,
  output logic [DROP_W-1:0] drop_count
);
  localparam logic [DROP_W-1:0] CNT_MAX = '1;

  logic              f_q, ovr_q;
  logic [DROP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q   <= 1'b0;
      ovr_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (vbl_edge)     f_q <= 1'b1;
      else if (stat_rd) f_q <= 1'b0;
      if (err_clr) begin
        ovr_q <= 1'b0;
        cnt_q <= '0;
      end else if (drop) begin
        ovr_q <= 1'b1;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign stat_data  = {f_q, 7'b0};
  assign irq        = f_q && irq_en;
  assign overrun    = ovr_q;
  assign drop_count = cnt_q;

  // R4
  f_set_chk: assert property (@(posedge clk) disable iff (rst)
    vbl_edge |=> f_q);
  // R5
  f_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !vbl_edge) |=> !f_q);
  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !err_clr) |=> ovr_q);
  // R10
  cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !err_clr |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/vframe_gate.sv
module vframe_gate #(
  parameter int LINE_CYCLES  = 228,
  parameter int ACTIVE_LINES = 192,
  parameter int LINES_60     = 262,
  parameter int LINES_50     = 313,
  parameter int GAP_ACTIVE   = 28,
  parameter int GAP_STRICT   = 22,
  parameter int DROP_W       = 16,
  parameter int LINE_W       = 9,
  parameter int CYC_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_50,
  input  logic              strict_gap,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              stat_rd,
  output logic [7:0]        stat_data,
  input  logic              irq_en,
  output logic              irq,
  input  logic              err_clr,
  output logic              overrun,
  output logic [DROP_W-1:0] drop_count,
  output logic [LINE_W-1:0] line,
  output logic [CYC_W-1:0]  cycle,
  output logic              in_blank,
  output logic              frame_start
);
  logic vbl_edge, drop;

  vfg_timebase #(
    .LINE_CYCLES(LINE_CYCLES), .ACTIVE_LINES(ACTIVE_LINES),
    .LINES_60(LINES_60), .LINES_50(LINES_50),
    .LINE_W(LINE_W), .CYC_W(CYC_W)
  ) u_tb (
    .clk(clk), .rst(rst), .mode_50(mode_50),
    .line_o(line), .cyc_o(cycle), .in_blank_o(in_blank),
    .frame_start_o(frame_start), .vbl_edge_o(vbl_edge)
  );

  vfg_gate #(
    .GAP_ACTIVE(GAP_ACTIVE), .GAP_STRICT(GAP_STRICT)
  ) u_gate (
    .clk(clk), .rst(rst), .strict(strict_gap), .in_blank(in_blank),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .drop_o(drop)
  );

  vfg_status #(.DROP_W(DROP_W)) u_stat (
    .clk(clk), .rst(rst), .vbl_edge(vbl_edge), .stat_rd(stat_rd),
    .irq_en(irq_en), .drop(drop), .err_clr(err_clr),
    .stat_data(stat_data), .irq(irq), .overrun(overrun),
    .drop_count(drop_count)
  );

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (stat_data[7] && irq_en));
  // R3
  blank_region_chk: assert property (@(posedge clk) disable iff (rst)
    in_blank == (line >= LINE_W'(ACTIVE_LINES)));
endmodule

// File: tb/vframe_gate_test.sv
module vframe_gate_test;
  localparam int LC = 10, AL = 4, L60 = 6, L50 = 7, GA = 5, GS = 3, DW = 4;
  localparam int CMAX = (1 << DW) - 1;

  logic clk = 1'b0, rst = 1'b1, mode_50 = 1'b0, strict_gap = 1'b0;
  logic wr_valid = 1'b0, stat_rd = 1'b0, irq_en = 1'b0, err_clr = 1'b0;
  logic wr_ready, irq, overrun, in_blank, frame_start;
  logic [7:0] stat_data;
  logic [DW-1:0] drop_count;
  logic [8:0] line;
  logic [7:0] cycle;

  int errors = 0, checks = 0;
  int m_cyc, m_line, m_fs, m_f, m_since, m_ovr, m_cnt;

  always #5 clk = ~clk;

  vframe_gate #(
    .LINE_CYCLES(LC), .ACTIVE_LINES(AL), .LINES_60(L60), .LINES_50(L50),
    .GAP_ACTIVE(GA), .GAP_STRICT(GS), .DROP_W(DW)
  ) uut (
    .clk(clk), .rst(rst), .mode_50(mode_50), .strict_gap(strict_gap),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .stat_rd(stat_rd),
    .stat_data(stat_data), .irq_en(irq_en), .irq(irq), .err_clr(err_clr),
    .overrun(overrun), .drop_count(drop_count), .line(line), .cycle(cycle),
    .in_blank(in_blank), .frame_start(frame_start)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (line %0d cycle %0d)",
               req, what, act, exp, m_line, m_cyc);
    end
  endtask

  task automatic model_init();
    m_cyc = 0; m_line = 0; m_fs = 0; m_f = 0; m_since = 1000; m_ovr = 0; m_cnt = 0;
  endtask

  // R11: reset state, gate open
  task automatic do_reset(bit m50, bit strict);
    rst = 1'b1; mode_50 = m50; strict_gap = strict;
    wr_valid = 1'b0; stat_rd = 1'b0; err_clr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model_init();
    chk("R11", "line", int'(line), 0);
    chk("R11", "cycle", int'(cycle), 0);
    chk("R11", "flag", int'(stat_data[7]), 0);
    chk("R11", "overrun", int'(overrun), 0);
    chk("R11", "drop_count", int'(drop_count), 0);
    chk("R11", "frame_start", int'(frame_start), 0);
    chk("R11", "wr_ready", int'(wr_ready), 1);
    rst = 1'b0;
  endtask

  task automatic tick(bit v, bit rd, bit en, bit clr);
    int fl, rdy, acc, drp, vbl, eol;
    string rq;
    wr_valid = v; stat_rd = rd; irq_en = en; err_clr = clr;
    #1;
    fl  = mode_50 ? L50 : L60;
    rdy = strict_gap ? (m_since >= GS) : ((m_line >= AL) || (m_since >= GA));
    rq  = strict_gap ? "R9" : ((m_line >= AL) ? "R7" : "R8");
    chk("R1", "cycle", int'(cycle), m_cyc);
    chk("R1", "line", int'(line), m_line);
    chk("R2", "frame_start", int'(frame_start), m_fs);
    chk("R3", "in_blank", int'(in_blank), int'(m_line >= AL));
    chk("R4", "flag", int'(stat_data[7]), m_f);
    chk("R4", "status low bits", int'(stat_data[6:0]), 0);
    chk("R6", "irq", int'(irq), m_f & int'(en));
    chk(rq, "wr_ready", int'(wr_ready), rdy);
    chk("R10", "overrun", int'(overrun), m_ovr);
    chk("R10", "drop_count", int'(drop_count), m_cnt);
    acc = int'(v) & rdy;
    drp = int'(v) & (1 - rdy);
    eol = (m_cyc == LC - 1);
    vbl = eol && (m_line == AL - 1);
    m_fs = eol && (m_line == fl - 1);
    if (vbl) m_f = 1; else if (rd) m_f = 0;
    if (acc != 0) m_since = 1; else if (m_since < 1000) m_since++;
    if (clr) begin m_ovr = 0; m_cnt = 0; end
    else if (drp != 0) begin m_ovr = 1; if (m_cnt < CMAX) m_cnt++; end
    if (eol) begin
      m_cyc = 0;
      m_line = (m_line == fl - 1) ? 0 : m_line + 1;
    end else m_cyc++;
    @(negedge clk);
  endtask

  task automatic run(int period, int ofs, int rdp, bit en, int clr_at, int n);
    for (int i = 0; i < n; i++)
      tick((i % period) == ofs, (rdp != 0) && ((i % rdp) == 0), en, i == clr_at);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R7 R8 R1 R2: 60 Hz, region rule, constant strobes, sparse reads, mid-run clear
    do_reset(1'b0, 1'b0);
    run(1, 0, 7, 1'b1, 50, 130);
    run(2, 1, 0, 1'b0, -1, 70);
    // R5 R2: 50 Hz, reads every cycle so set and clear meet
    do_reset(1'b1, 1'b0);
    run(3, 0, 1, 1'b1, -1, 150);
    // R9 R10: fixed rule, saturation, clear, then sparse strobes
    do_reset(1'b1, 1'b1);
    run(1, 0, 0, 1'b1, -1, 80);
    run(4, 2, 0, 1'b1, 0, 60);
    do_reset(1'b0, 1'b1);
    run(2, 0, 5, 1'b1, -1, 100);
    // sweep of strobe periods under both rules and both frame lengths
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 2; m++)
        for (int p = 1; p <= 7; p++) begin
          do_reset(m[0], s[0]);
          run(p, 0, 9, p[0], 33, 90);
        end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule